// File: doc/BRIEF.md
# Multiplexed Converter Pin Sequencer

This block sits on the host side of an eight-input successive-approximation converter and drives its parallel control pins. A client asks for a conversion by giving a channel number on a ready/valid request port. The sequencer puts the channel on the address pins, waits out the address setup time, raises the address latch strobe, keeps the address steady for the hold time, then pulses the start pin.

After the start pulse the converter's end-of-conversion flag cannot be trusted for a while, so the sequencer ignores it during a blanking window. It then waits for the flag to go low and come back high, with a single timeout budget that covers both waits. Once the flag is back high it raises the output enable, waits for the data bus to settle, captures the byte and returns it with the channel number and a one-cycle valid strobe. If the flag never completes, a one-cycle error pulse is raised instead and the sequencer goes back to idle.

Every delay is given in nanoseconds and turned into host clock cycles, rounded up. The end-of-conversion input is asynchronous and passes through a two-flop synchronizer before the control logic sees it.

Top module: `mux_adc_sequencer`

## Requirements
- R1: After reset the latch strobe, start and output enable pins are low, `reqReady` is high, and `resValid` and `timeoutErr` are low.
- R2: When a request is accepted, `adcAddr` takes the 3-bit channel number in plain binary (0 to 7). It holds that value for at least ceil(setup_ns/clk_ns) cycles before `adcAle` rises.
- R3: `adcAle` stays high for exactly ceil(ale_ns/clk_ns) cycles.
- R4: `adcAddr` does not change while the latch strobe is high or during the hold time. `adcStart` rises exactly ceil(hold_ns/clk_ns) cycles after `adcAle` falls.
- R5: `adcStart` stays high for exactly ceil(start_ns/clk_ns) cycles.
- R6: `adcOe` never rises sooner than the start width plus ceil((8*conv_clk_ns + eoc_extra_ns)/clk_ns) cycles after `adcStart` rises, whatever `adcEoc` does in that time.
- R7: `adcOe` rises only after `adcEoc` has fallen and then risen again. It rises 1 to 4 cycles after the rising edge of `adcEoc`.
- R8: `adcOe` stays high for ceil(oe_ns/clk_ns)+1 cycles. The byte on `adcData` in the last of those cycles appears on `resData` with a one-cycle `resValid` pulse in the cycle after `adcOe` falls.
- R9: `resChan` carries the channel number of the conversion whose byte is on `resData`.
- R10: If the end-of-conversion flag has not fallen and risen again within ceil(timeout_ns/clk_ns) cycles of the end of the blanking window, `timeoutErr` pulses for one cycle, `resValid` stays low and `reqReady` goes high again.
- R11: `reqReady` is low from acceptance until the sequence ends. A request held valid while busy is accepted later and is not lost.
- R12: The latch strobe, start and output enable pins are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Conversion request valid |
| reqChan | input | CHAN_W | Requested channel number |
| reqReady | output | 1 | Sequencer idle, request accepted when valid |
| resValid | output | 1 | One-cycle strobe: result available |
| resData | output | DATA_W | Captured conversion byte |
| resChan | output | CHAN_W | Channel tag of the result |
| timeoutErr | output | 1 | One-cycle pulse: conversion never completed |
| adcAddr | output | CHAN_W | Channel address pins |
| adcAle | output | 1 | Address latch strobe (converter latches on rising edge) |
| adcStart | output | 1 | Start-conversion pulse |
| adcOe | output | 1 | Output enable for the converter data bus |
| adcEoc | input | 1 | Asynchronous end-of-conversion flag (low while busy) |
| adcData | input | DATA_W | Converter data bus |

## Verification
A wrong state or a counter off by one shows up within one conversion as a pin pulse that is too short or too long, or as a pulse edge placed wrongly against its neighbour. The bench measures each of these in cycles. If the blanking window or the end-of-conversion tracking is wrong, the output enable rises at the wrong time relative to the start pulse or the modelled flag edge. If the capture is placed wrongly, the sequencer takes the bus while the model is still driving a settling pattern, and the returned byte is wrong. The timeout paths are checked by the cycle in which the error pulse arrives and by the absence of any result.

// File: rtl/mux_adc_pkg.sv
package mux_adc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SETUP,
    ST_ALE,
    ST_ADDR_HOLD,
    ST_START,
    ST_BLANK,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_OE_WAIT,
    ST_CAPTURE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;
    logic capture;
    logic timeout;
  } seqStrobe_t;

  // ceiling conversion of a nanosecond delay to clock cycles, at least one
  function automatic int nsToCycles(int ns, int periodNs);
    int r;
    r = (ns + periodNs - 1) / periodNs;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mux_adc_ctrl.sv
module mux_adc_ctrl
  import mux_adc_pkg::*;
#(
  parameter int SETUP_CYC   = 3,
  parameter int ALE_CYC     = 10,
  parameter int HOLD_CYC    = 3,
  parameter int START_CYC   = 10,
  parameter int BLANK_CYC   = 726,
  parameter int OE_CYC      = 13,
  parameter int TIMEOUT_CYC = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       eocSync,
  output logic       reqReady,
  output logic       adcAle,
  output logic       adcStart,
  output logic       adcOe,
  output seqStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(SETUP_CYC, ALE_CYC), maxOf(HOLD_CYC, START_CYC)),
                                 maxOf(maxOf(BLANK_CYC, OE_CYC), TIMEOUT_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  function automatic logic [CNT_W-1:0] loadFor(seqState_t s);
    case (s)
      ST_ADDR_SETUP: return CNT_W'(SETUP_CYC - 1);
      ST_ALE:        return CNT_W'(ALE_CYC - 1);
      ST_ADDR_HOLD:  return CNT_W'(HOLD_CYC - 1);
      ST_START:      return CNT_W'(START_CYC - 1);
      ST_BLANK:      return CNT_W'(BLANK_CYC - 1);
      ST_WAIT_LOW:   return CNT_W'(TIMEOUT_CYC - 1);
      ST_OE_WAIT:    return CNT_W'(OE_CYC - 1);
      default:       return '0;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        nextState      = ST_ADDR_SETUP;
        strobe.takeReq = 1'b1;
      end
      ST_ADDR_SETUP: if (cntDone) nextState = ST_ALE;
      ST_ALE:        if (cntDone) nextState = ST_ADDR_HOLD;
      ST_ADDR_HOLD:  if (cntDone) nextState = ST_START;
      ST_START:      if (cntDone) nextState = ST_BLANK;
      ST_BLANK:      if (cntDone) nextState = ST_WAIT_LOW;
      ST_WAIT_LOW: begin
        if (!eocSync) nextState = ST_WAIT_HIGH;
        else if (cntDone) begin
          nextState      = ST_IDLE;
          strobe.timeout = 1'b1;
        end
      end
      ST_WAIT_HIGH: begin
        if (eocSync) nextState = ST_OE_WAIT;
        else if (cntDone) begin
          nextState      = ST_IDLE;
          strobe.timeout = 1'b1;
        end
      end
      ST_OE_WAIT: if (cntDone) nextState = ST_CAPTURE;
      ST_CAPTURE: begin
        nextState      = ST_IDLE;
        strobe.capture = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      adcAle   <= 1'b0;
      adcStart <= 1'b0;
      adcOe    <= 1'b0;
    end else begin
      state <= nextState;
      // one timeout budget spans both end-of-conversion waits
      if (nextState != state && nextState != ST_WAIT_HIGH) cnt <= loadFor(nextState);
      else if (!cntDone) cnt <= cnt - 1'b1;
      adcAle   <= (nextState == ST_ALE);
      adcStart <= (nextState == ST_START);
      adcOe    <= (nextState == ST_OE_WAIT) || (nextState == ST_CAPTURE);
    end
  end

endmodule

// File: rtl/mux_adc_dpath.sv
module mux_adc_dpath
  import mux_adc_pkg::*;
#(
  parameter int CHAN_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              adcEoc,
  input  logic [DATA_W-1:0] adcData,
  output logic              eocSync,
  output logic [CHAN_W-1:0] adcAddr,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [CHAN_W-1:0] resChan,
  output logic              timeoutErr
);

  logic [SYNC_STAGES-1:0] syncPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], adcEoc};
  end
  assign eocSync = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcAddr    <= '0;
      resValid   <= 1'b0;
      resData    <= '0;
      resChan    <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobe.takeReq) adcAddr <= reqChan;
      resValid   <= strobe.capture;
      timeoutErr <= strobe.timeout;
      if (strobe.capture) begin
        resData <= adcData;
        resChan <= adcAddr;
      end
    end
  end

endmodule

// File: rtl/mux_adc_sequencer.sv
module mux_adc_sequencer
  import mux_adc_pkg::*;
#(
  parameter int CHAN_W       = 3,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 20,
  parameter int SETUP_NS     = 50,
  parameter int HOLD_NS      = 50,
  parameter int ALE_NS       = 200,
  parameter int START_NS     = 200,
  parameter int CONV_CLK_NS  = 1563,
  parameter int EOC_EXTRA_NS = 2000,
  parameter int OE_NS        = 250,
  parameter int TIMEOUT_NS   = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CHAN_W-1:0] reqChan,
  output logic              reqReady,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [CHAN_W-1:0] resChan,
  output logic              timeoutErr,
  output logic [CHAN_W-1:0] adcAddr,
  output logic              adcAle,
  output logic              adcStart,
  output logic              adcOe,
  input  logic              adcEoc,
  input  logic [DATA_W-1:0] adcData
);

  localparam int SETUP_CYC   = nsToCycles(SETUP_NS, CLK_NS);
  localparam int HOLD_CYC    = nsToCycles(HOLD_NS, CLK_NS);
  localparam int ALE_CYC     = nsToCycles(ALE_NS, CLK_NS);
  localparam int START_CYC   = nsToCycles(START_NS, CLK_NS);
  localparam int BLANK_CYC   = nsToCycles(8 * CONV_CLK_NS + EOC_EXTRA_NS, CLK_NS);
  localparam int OE_CYC      = nsToCycles(OE_NS, CLK_NS);
  localparam int TIMEOUT_CYC = nsToCycles(TIMEOUT_NS, CLK_NS);

  seqStrobe_t strobe;
  logic eocSync;

  mux_adc_ctrl #(
    .SETUP_CYC(SETUP_CYC), .ALE_CYC(ALE_CYC), .HOLD_CYC(HOLD_CYC),
    .START_CYC(START_CYC), .BLANK_CYC(BLANK_CYC), .OE_CYC(OE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .eocSync(eocSync),
    .reqReady(reqReady), .adcAle(adcAle), .adcStart(adcStart),
    .adcOe(adcOe), .strobe(strobe)
  );

  mux_adc_dpath #(.CHAN_W(CHAN_W), .DATA_W(DATA_W), .SYNC_STAGES(2)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqChan(reqChan),
    .adcEoc(adcEoc), .adcData(adcData), .eocSync(eocSync),
    .adcAddr(adcAddr), .resValid(resValid), .resData(resData),
    .resChan(resChan), .timeoutErr(timeoutErr)
  );

endmodule

// File: rtl/mux_adc_checker.sv
module mux_adc_checker #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [CHAN_W-1:0] adcAddr,
  input logic              adcAle,
  input logic              adcStart,
  input logic              adcOe,
  input logic              resValid,
  input logic              timeoutErr
);

  assert_pins_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adcAle, adcStart, adcOe}));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcAle) |-> $stable(adcAddr));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (adcAle || $fell(adcAle)) |-> $stable(adcAddr));

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    (adcAle || adcStart || adcOe) |-> !reqReady);

  assert_valid_after_oe_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($past(adcOe) && !adcOe));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_error_no_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!resValid && reqReady));

endmodule

bind mux_adc_sequencer mux_adc_checker #(.CHAN_W(CHAN_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .adcAddr(adcAddr),
  .adcAle(adcAle), .adcStart(adcStart), .adcOe(adcOe),
  .resValid(resValid), .timeoutErr(timeoutErr)
);

// File: tb/mux_adc_sequencer_tb_top.sv
module mux_adc_sequencer_tb_top;

  localparam int CLK_NS  = 20;
  localparam int CONV_NS = 100;
  localparam int TO_NS   = 8000;
  localparam int C_SETUP = (50 + CLK_NS - 1) / CLK_NS;
  localparam int C_HOLD  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int C_ALE   = (200 + CLK_NS - 1) / CLK_NS;
  localparam int C_START = (200 + CLK_NS - 1) / CLK_NS;
  localparam int C_BLANK = (8 * CONV_NS + 2000 + CLK_NS - 1) / CLK_NS;
  localparam int C_OE    = (250 + CLK_NS - 1) / CLK_NS;
  localparam int C_TO    = (TO_NS + CLK_NS - 1) / CLK_NS;
  localparam int MODEL_OE_DLY = 12;
  localparam int MODEL_CONV   = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqChan = '0;
  logic       reqReady, resValid, timeoutErr;
  logic [7:0] resData;
  logic [2:0] resChan, adcAddr;
  logic       adcAle, adcStart, adcOe;
  logic       adcEoc = 1'b1;
  logic [7:0] adcData = 8'h5A;

  always #10 clk = ~clk;

  mux_adc_sequencer #(
    .CLK_NS(CLK_NS), .CONV_CLK_NS(CONV_NS), .TIMEOUT_NS(TO_NS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqReady(reqReady), .resValid(resValid), .resData(resData),
    .resChan(resChan), .timeoutErr(timeoutErr), .adcAddr(adcAddr),
    .adcAle(adcAle), .adcStart(adcStart), .adcOe(adcOe),
    .adcEoc(adcEoc), .adcData(adcData)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  int mode = 0;        // 0 normal, 1 flag never falls, 2 flag never rises
  int fallDly = 3;
  int accQ [0:63];
  int accWr = 0, aleIdx = 0;
  int curChan = 0, convIdx = 0, expVal = 0;
  int addrChg = 0, aleRise = 0, aleFall = 0, startRise = 0, oeRise = 0;
  int fallAt = -1, riseAt = -1, eocRiseCyc = -1;
  int resCnt = 0, toCnt = 0, lastResChan = -1;
  logic [2:0] prevAddr = '0;
  logic pAle = 0, pStart = 0, pOe = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model and pin monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (adcAddr !== prevAddr) addrChg = cyc;
    prevAddr = adcAddr;
    if (adcAle && !pAle) begin
      chk(cyc - addrChg >= C_SETUP, "R2", "address setup cycles", cyc - addrChg, C_SETUP);
      curChan = accQ[aleIdx];
      aleIdx++;
      chk(int'(adcAddr) == curChan, "R2", "binary channel address", int'(adcAddr), curChan);
      aleRise = cyc;
    end
    if (!adcAle && pAle) begin
      chk(cyc - aleRise == C_ALE, "R3", "latch strobe width", cyc - aleRise, C_ALE);
      aleFall = cyc;
    end
    if (adcStart && !pStart) begin
      chk(cyc - aleFall == C_HOLD, "R4", "hold before start", cyc - aleFall, C_HOLD);
      chk(addrChg < aleRise, "R4", "address changed after latch", addrChg, aleRise);
      startRise = cyc;
      eocRiseCyc = -1;
      expVal = (curChan * 37 + convIdx * 11 + 5) % 256;
      convIdx++;
      fallAt = (mode == 1) ? -1 : cyc + fallDly;
      riseAt = -1;
    end
    if (!adcStart && pStart)
      chk(cyc - startRise == C_START, "R5", "start width", cyc - startRise, C_START);
    if (cyc == fallAt) begin
      adcEoc = 1'b0;
      if (mode == 0) riseAt = cyc + MODEL_CONV;
    end
    if (cyc == riseAt) begin
      adcEoc = 1'b1;
      eocRiseCyc = cyc;
    end
    if (adcOe && !pOe) begin
      chk(cyc - startRise >= C_START + C_BLANK, "R6", "blanking respected",
          cyc - startRise, C_START + C_BLANK);
      chk(eocRiseCyc >= 0 && cyc - eocRiseCyc >= 1 && cyc - eocRiseCyc <= 4, "R7",
          "enable after flag edge", cyc - eocRiseCyc, 3);
      oeRise = cyc;
    end
    if (!adcOe && pOe)
      chk(cyc - oeRise == C_OE + 1, "R8", "output enable width", cyc - oeRise, C_OE + 1);
    if (adcOe) adcData = (cyc - oeRise >= MODEL_OE_DLY) ? 8'(expVal) : 8'hEE;
    else       adcData = 8'h5A;
    if (resValid) begin
      resCnt++;
      chk(int'(resData) == expVal, "R8", "captured byte", int'(resData), expVal);
      chk(int'(resChan) == curChan, "R9", "channel tag", int'(resChan), curChan);
      lastResChan = int'(resChan);
    end
    if (timeoutErr) begin
      toCnt++;
      chk(cyc - startRise == C_START + C_BLANK + C_TO, "R10", "timeout cycle",
          cyc - startRise, C_START + C_BLANK + C_TO);
    end
    if ((adcAle || adcStart || adcOe) && reqReady)
      chk(1'b0, "R11", "ready while busy", 1, 0);
    pAle = adcAle; pStart = adcStart; pOe = adcOe;
  end

  // called on a falling edge; returns on the falling edge after acceptance
  task automatic sendReq(input int ch);
    reqChan  = 3'(ch);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    accQ[accWr] = ch;
    accWr++;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitEnd();
    int r0, t0;
    r0 = resCnt; t0 = toCnt;
    while (resCnt == r0 && toCnt == t0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !adcAle && !adcStart && !adcOe && !resValid && !timeoutErr,
        "R1", "reset state", {reqReady, adcAle, adcStart, adcOe, resValid, timeoutErr}, 6'b100000);

    // every channel against three flag timings, one of them past the blanking window
    for (int ch = 0; ch < 8; ch++) begin
      for (int k = 0; k < 3; k++) begin
        mode = 0;
        fallDly = (k == 0) ? 3 : (k == 1) ? 80 : 160;
        r0 = resCnt;
        sendReq(ch);
        waitEnd();
        chk(resCnt == r0 + 1, "R8", "result delivered", resCnt - r0, 1);
      end
    end

    // R11: request held valid while busy
    mode = 0; fallDly = 3;
    r0 = resCnt;
    sendReq(2);
    reqChan = 3'd6; reqValid = 1'b1;
    chk(!reqReady, "R11", "not ready after accept", int'(reqReady), 0);
    sendReq(6);
    while (resCnt < r0 + 2) @(negedge clk);
    @(negedge clk);
    chk(resCnt == r0 + 2, "R11", "both requests served", resCnt - r0, 2);
    chk(lastResChan == 6, "R11", "held request channel", lastResChan, 6);

    // R10: flag never falls, then flag never rises
    for (int m = 1; m < 3; m++) begin
      mode = m; fallDly = 3;
      r0 = resCnt; t0 = toCnt;
      sendReq(4);
      waitEnd();
      chk(toCnt == t0 + 1, "R10", "timeout pulse", toCnt - t0, 1);
      chk(resCnt == r0, "R10", "no result on timeout", resCnt - r0, 0);
      chk(reqReady, "R10", "ready after timeout", int'(reqReady), 1);
      adcEoc = 1'b1;
    end

    // recovery after timeout
    mode = 0; fallDly = 80;
    r0 = resCnt;
    sendReq(7);
    waitEnd();
    chk(resCnt == r0 + 1, "R10", "conversion after timeout", resCnt - r0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule